// File: doc/BRIEF.md
# Conversion Result Holding Register with Compare Gating

This block captures the output of an analog-to-digital converter and presents it to a processor as two read-only byte registers: a high byte and a low byte. A converter delivers a 10-bit sample together with a one-cycle completion strobe. The block either stores the sample or drops it. It stores the sample unless a compare gate is enabled and its condition fails, a coherent two-byte read is in progress, or the resolution setting has just changed.

Two resolutions are supported. In wide (10-bit) mode, the two most significant sample bits sit in the bottom of the high byte and the other eight bits form the low byte. In narrow (8-bit) mode, the low byte carries the eight most significant sample bits and the high byte reads zero. In wide mode, a high-byte read locks the registers until the matching low-byte read, so software always sees both halves of one sample. A completion flag shows that a fresh sample has been stored since the last low-byte read.

Top module: `adc_result_hold`

## Requirements
- R1: High byte bits 7:2 always read 0. In wide mode (`wide_mode`=1), a stored sample places sample bits 9:8 in high byte bits 1:0.
- R2: A stored sample sets the low byte to sample bits 7:0 in wide mode, or to sample bits 9:2 in narrow mode (`wide_mode`=0).
- R3: A sample stored in narrow mode leaves the high byte at 0.
- R4: With `cmp_en`=0, every `conv_done` pulse outside a lock or mode-change cycle is stored. The registers show the sample one cycle after the strobe.
- R5: With `cmp_en`=1 and `cmp_ge`=0, a sample is stored only when its compare value is below the compare limit. Otherwise both registers keep their old contents.
- R6: With `cmp_en`=1 and `cmp_ge`=1, a sample is stored only when its compare value is greater than or equal to the compare limit.
- R7: In wide mode, the compare value is the full 10-bit sample and the limit is the full `cmp_level`. In narrow mode, the value is sample bits 9:2 and the limit is `cmp_level` bits 7:0.
- R8: In wide mode, a `rd_hi` pulse blocks storage from that cycle on, up to and including the next `rd_lo` cycle. Samples completing in that window are lost.
- R9: In narrow mode, `rd_hi` has no effect on storage.
- R10: A change of `wide_mode`, seen one cycle after it is applied, clears the high byte and releases the lock. A sample completing in that cycle is dropped. The mode tracker resets to narrow, so the first cycle after reset with wide mode applied also counts as a change.
- R11: `done_flag` sets on every store and clears on `rd_lo`. A store in the same cycle as `rd_lo` leaves it set.
- R12: After reset, both bytes and `done_flag` are 0 and the lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle sample-complete strobe |
| conv_data | input | 10 | Sample value, valid with conv_done |
| wide_mode | input | 1 | 1 = 10-bit layout, 0 = 8-bit layout |
| cmp_en | input | 1 | Enables compare gating of stores |
| cmp_ge | input | 1 | 0 = store when below limit, 1 = store when at or above |
| cmp_level | input | 10 | Compare limit |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| done_flag | output | 1 | Fresh sample stored since last low-byte read |

## Verification
On every cycle, the assertions check the following:
- The high byte's upper six bits stay zero.
- A narrow-mode store leaves the high byte at zero.
- The registers hold still whenever nothing is stored, including samples that arrive during a lock window.
- The lock only exists in wide mode and drops on a low-byte read or a mode change.
- The completion flag follows stores and low-byte reads.

Only the bench's scenarios can show the rest:
- The compare arithmetic is right across sweeps of samples, limits and both directions.
- Each byte holds the correct bit slice in each mode.
- The two bytes returned by a locked read sequence come from one sample.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int RES_W = 10;
  localparam int REG_W = 8;
  localparam int HI_W  = RES_W - REG_W;

  typedef logic [RES_W-1:0] res_t;
  typedef logic [REG_W-1:0] byte_t;

  // high register image: upper sample bits in wide layout, zero otherwise
  function automatic byte_t pick_hi(input res_t d, input logic wide);
    byte_t r;
    r = '0;
    if (wide) r[HI_W-1:0] = d[RES_W-1:REG_W];
    return r;
  endfunction

  // low register image: lower bits in wide layout, top bits in narrow layout
  function automatic byte_t pick_lo(input res_t d, input logic wide);
    return wide ? d[REG_W-1:0] : d[RES_W-1:HI_W];
  endfunction

  // value the compare sees, zero-extended to the full width
  function automatic res_t cmp_value(input res_t d, input logic wide);
    res_t v;
    v = '0;
    if (wide) v = d;
    else      v[REG_W-1:0] = d[RES_W-1:HI_W];
    return v;
  endfunction

  // limit the compare sees
  function automatic res_t cmp_limit(input res_t lvl, input logic wide);
    res_t l;
    l = '0;
    if (wide) l = lvl;
    else      l[REG_W-1:0] = lvl[REG_W-1:0];
    return l;
  endfunction

  function automatic logic cmp_trigger(input res_t v, input res_t l, input logic ge);
    return ge ? (v >= l) : (v < l);
  endfunction
endpackage

// File: rtl/adc_cmp_gate.sv
module adc_cmp_gate
  import adc_res_pkg::*;
(
  input  res_t conv_data,
  input  res_t cmp_level,
  input  logic wide_mode,
  input  logic cmp_en,
  input  logic cmp_ge,
  output logic keep_ok
);
  res_t value_w;
  res_t limit_w;
  logic hit_w;

  always_comb begin
    value_w = cmp_value(conv_data, wide_mode);
    limit_w = cmp_limit(cmp_level, wide_mode);
    hit_w   = cmp_trigger(value_w, limit_w, cmp_ge);
    keep_ok = !cmp_en || hit_w;
  end

  // R7: the narrow-mode compare value never exceeds one byte
  always_comb begin
    if (!wide_mode) begin
      p_narrow_value_r7: assert (value_w[RES_W-1:REG_W] == '0);
    end
  end
endmodule

// File: rtl/adc_read_lock.sv
module adc_read_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_mode,
  input  logic rd_hi,
  input  logic rd_lo,
  output logic mode_chg,
  output logic locked,
  output logic block_now
);
  logic mode_q;
  logic lock_d;

  assign mode_chg  = (wide_mode != mode_q);
  assign block_now = !mode_chg && (locked || (rd_hi && wide_mode));

  always_comb begin
    lock_d = locked;
    if (mode_chg)               lock_d = 1'b0;
    else if (rd_lo)             lock_d = 1'b0;
    else if (rd_hi && wide_mode) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      locked <= 1'b0;
    end else begin
      mode_q <= wide_mode;
      locked <= lock_d;
    end
  end

  // R9: a held lock only exists while the wide layout is in force
  p_lock_wide_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> mode_q);
  // R8: a low-byte read always releases the lock
  p_lock_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !locked);
  // R10: a mode change always releases the lock
  p_mode_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !locked);
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store
  import adc_res_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  store,
  input  logic  mode_chg,
  input  logic  wide_mode,
  input  res_t  conv_data,
  input  logic  rd_lo,
  output byte_t res_hi,
  output byte_t res_lo,
  output logic  done_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi    <= '0;
      res_lo    <= '0;
      done_flag <= 1'b0;
    end else begin
      if (store) begin
        res_hi <= pick_hi(conv_data, wide_mode);
        res_lo <= pick_lo(conv_data, wide_mode);
      end else if (mode_chg) begin
        res_hi <= '0;
      end
      if (store)      done_flag <= 1'b1;
      else if (rd_lo) done_flag <= 1'b0;
    end
  end

  // R1: upper six bits of the high byte never carry data
  p_hi_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_hi[REG_W-1:HI_W] == '0);
  // R3: a narrow store yields a zero high byte
  p_narrow_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !wide_mode) |=> (res_hi == '0));
  // R4: no store leaves the low byte untouched
  p_lo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !store |=> $stable(res_lo));
  // R10: mode change without store clears the high byte
  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !store) |=> (res_hi == '0));
  // R11: store sets the flag, a read without store clears it
  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> done_flag);
  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !store) |=> !done_flag);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_res_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             wide_mode,
  input  logic             cmp_en,
  input  logic             cmp_ge,
  input  logic [RES_W-1:0] cmp_level,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [REG_W-1:0] res_hi,
  output logic [REG_W-1:0] res_lo,
  output logic             done_flag
);
  logic keep_ok;
  logic mode_chg;
  logic locked;
  logic block_now;
  logic store;

  adc_cmp_gate u_gate (
    .conv_data (conv_data),
    .cmp_level (cmp_level),
    .wide_mode (wide_mode),
    .cmp_en    (cmp_en),
    .cmp_ge    (cmp_ge),
    .keep_ok   (keep_ok)
  );

  adc_read_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .mode_chg  (mode_chg),
    .locked    (locked),
    .block_now (block_now)
  );

  assign store = conv_done && keep_ok && !block_now && !mode_chg;

  adc_res_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .store     (store),
    .mode_chg  (mode_chg),
    .wide_mode (wide_mode),
    .conv_data (conv_data),
    .rd_lo     (rd_lo),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .done_flag (done_flag)
  );

  // R8: a sample arriving inside the lock window changes neither byte
  p_lock_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && block_now) |=> ($stable(res_lo) && $stable(res_hi)));
  // R5/R6: a compare failure stores nothing
  p_cmp_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !keep_ok) |=> $stable(res_lo));
  // R11: the flag cannot rise without a stored sample
  p_flag_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(conv_done));
endmodule

// File: tb/adc_result_hold_bench.sv
module adc_result_hold_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       wide_mode = 1'b0;
  logic       cmp_en = 1'b0;
  logic       cmp_ge = 1'b0;
  logic [9:0] cmp_level = '0;
  logic       rd_hi = 1'b0;
  logic       rd_lo = 1'b0;
  logic [7:0] res_hi;
  logic [7:0] res_lo;
  logic       done_flag;

  int checks = 0;
  int errors = 0;
  int e_hi = 0, e_lo = 0, e_flag = 0;
  bit e_lock = 0;
  bit prev_wide = 0;

  always #10 clk = ~clk;

  adc_result_hold u_adc_result_hold (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .wide_mode(wide_mode), .cmp_en(cmp_en), .cmp_ge(cmp_ge), .cmp_level(cmp_level),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .res_hi(res_hi), .res_lo(res_lo), .done_flag(done_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit passes(input int d, input int lvl, input bit wide, input bit en, input bit ge);
    int v, l;
    if (!en) return 1'b1;
    v = wide ? d : d / 4;
    l = wide ? lvl : lvl % 256;
    return ge ? (v >= l) : (v < l);
  endfunction

  // one clock with the given strobes; model follows the requirements
  task automatic cyc(input bit done, input int d, input bit rh, input bit rl);
    bit mchg, blk, st;
    conv_done = done; conv_data = 10'(d); rd_hi = rh; rd_lo = rl;
    mchg = (wide_mode != prev_wide);
    blk  = !mchg && (e_lock || (rh && wide_mode));
    st   = done && !mchg && !blk && passes(d, int'(cmp_level), wide_mode, cmp_en, cmp_ge);
    if (st) begin
      e_hi = wide_mode ? d / 256 : 0;
      e_lo = wide_mode ? d % 256 : d / 4;
    end else if (mchg) e_hi = 0;
    if (st) e_flag = 1; else if (rl) e_flag = 0;
    if (mchg || rl) e_lock = 0; else if (rh && wide_mode) e_lock = 1;
    prev_wide = wide_mode;
    @(posedge clk);
    @(negedge clk);
    conv_done = 0; rd_hi = 0; rd_lo = 0;
  endtask

  task automatic chk_all(input string thi, input string tlo, input string tfl);
    chk(thi, int'(res_hi), e_hi);
    chk(tlo, int'(res_lo), e_lo);
    chk(tfl, int'(done_flag), e_flag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int levels[4] = '{0, 200, 517, 1023};
    wide_mode = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    chk("R12", int'(res_hi), 0);
    chk("R12", int'(res_lo), 0);
    chk("R12", int'(done_flag), 0);
    cyc(0, 0, 0, 0); // first cycle counts as mode change (R10)

    // sweep: both modes, compare off/on, both directions, several limits
    for (int m = 1; m >= 0; m--) begin
      wide_mode = m[0];
      cyc(0, 0, 0, 0);
      for (int en = 0; en < 2; en++)
        for (int ge = 0; ge < 2; ge++)
          for (int li = 0; li < 4; li++) begin
            cmp_en = en[0]; cmp_ge = ge[0]; cmp_level = 10'(levels[li]);
            for (int d = 0; d < 1024; d += 29) begin
              cyc(1, d, 0, 0);
              chk_all(m ? "R1" : "R3", en == 0 ? "R4" : (ge ? "R6" : "R5"), "R11");
            end
          end
    end
    cmp_en = 0;

    // R2: byte slicing in both modes
    wide_mode = 1; cyc(0, 0, 0, 0);
    cyc(1, 10'h2A5, 0, 0);
    chk("R1", int'(res_hi), 2); chk("R2", int'(res_lo), 8'hA5);
    wide_mode = 0; cyc(0, 0, 0, 0);
    chk("R10", int'(res_hi), 0);
    cyc(1, 10'h2A5, 0, 0);
    chk("R2", int'(res_lo), 8'hA9); chk("R3", int'(res_hi), 0);

    // R7: narrow compare uses level bits 7:0; full-width compare would reject
    cmp_en = 1; cmp_ge = 0; cmp_level = 10'h1FF;
    cyc(1, 10'h3F8, 0, 0);
    chk("R7", int'(res_lo), 8'hFE);
    wide_mode = 1; cyc(0, 0, 0, 0);
    cyc(1, 10'h3F8, 0, 0);
    chk("R7", int'(res_lo), 8'hFE); chk("R7", int'(res_hi), 0);
    cmp_en = 0;

    // R8: coherent read sequence in wide mode
    cyc(1, 10'h1C3, 0, 0);
    chk("R8", int'(res_hi), 1);
    cyc(1, 10'h37E, 1, 0);       // read high while a sample lands: dropped
    chk_all("R8", "R8", "R11");
    cyc(1, 10'h2B1, 0, 0);       // dropped while locked
    chk("R8", int'(res_lo), 8'hC3); chk("R8", int'(res_hi), 1);
    cyc(1, 10'h0F0, 0, 1);       // low read cycle still blocks
    chk("R8", int'(res_lo), 8'hC3);
    chk("R11", int'(done_flag), 0);
    cyc(1, 10'h0F0, 0, 0);       // released
    chk("R8", int'(res_lo), 8'hF0); chk("R8", int'(res_hi), 0);

    // R10: mode change releases lock, clears high, drops coincident sample
    cyc(1, 10'h3C0, 0, 0);
    cyc(0, 0, 1, 0);
    wide_mode = 0;
    cyc(1, 10'h155, 0, 0);
    chk("R10", int'(res_hi), 0); chk("R10", int'(res_lo), 8'hC0);
    cyc(1, 10'h155, 0, 0);
    chk("R10", int'(res_lo), 8'h55);

    // R9: narrow mode, high read does not block
    cyc(0, 0, 1, 0);
    cyc(1, 10'h204, 1, 0);
    chk("R9", int'(res_lo), 8'h81);
    cyc(1, 10'h3FC, 0, 0);
    chk("R9", int'(res_lo), 8'hFF);

    // R11: store in the same cycle as a low read keeps the flag set
    cyc(1, 10'h010, 0, 1);
    chk("R11", int'(done_flag), 1); chk("R11", int'(res_lo), 8'h04);
    cyc(0, 0, 0, 1);
    chk("R11", int'(done_flag), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule